// File: doc/BRIEF.md
# Serial Memory Status and Write Guard

This block keeps the status byte of a serial nonvolatile memory and decides, for every byte the SPI engine is about to store, whether the store may go ahead. The engine decodes the instructions and passes single-cycle strobes to this block. Those strobes are arm, disarm, status update with a data byte, and end of array write. The block answers with the current status byte and with a registered grant for each address the engine presents.

Two kinds of protection are combined. The first is an arm latch, which must be set before any write and clears itself once that write has finished. The second is a two-bit region selector that locks the top quarter, the top half or all of the array against array writes. The selector is in turn guarded by an external active-low lock pin. The pin counts only when a pin-enable bit in the status byte is set, so firmware decides whether the board-level lock is honoured.

The protocol reset `rst` clears only the arm latch and the grant, because the selector and pin-enable bits stand for stored values. A separate `nv_rst` gives those stored bits their defined power-up value of zero.

Top module: `stat_guard`

## Requirements
- R1: The status byte carries the pin-enable bit at bit 7, the region selector at bits 3:2 and the arm latch at bit 1. Bits 6:4 and bit 0 always read 0.
- R2: An arm strobe alone sets the arm latch, and the latch shows in the status byte after that clock edge.
- R3: A disarm strobe, an end-of-array-write strobe or a status-update strobe clears the arm latch at that edge. When any of them arrives in the same cycle as an arm strobe, the clear wins.
- R4: A status update while the arm latch is 0 changes neither the selector nor the pin-enable bit.
- R5: A status update is rejected when pin-enable is 1 and `lock_pin_n` is low. The arm latch is cleared even so.
- R6: An accepted status update takes bit 7 and bits 3:2 of `stat_wdata` and ignores its other bits. When pin-enable is 0 the level of `lock_pin_n` has no effect.
- R7: The selector codes are 00 for no region, 01 for 0x6000–0x7FFF, 10 for 0x4000–0x7FFF and 11 for the whole array (ADDR_W=15). The region is derived from the top address bits for any ADDR_W.
- R8: `byte_grant` is 1 in the cycle after `byte_req` only if the arm latch was 1 and the address lay outside the locked region in the cycle of the request. Otherwise it is 0.
- R9: `rst` clears the arm latch and `byte_grant` but keeps the selector and pin-enable bits. `nv_rst` clears all of them.
- R10: The first address below each region start is granted and the region start itself is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous protocol reset, active high |
| nv_rst | input | 1 | Synchronous reset of the stored bits, active high |
| cmd_arm | input | 1 | Arm strobe (write enable) |
| cmd_disarm | input | 1 | Disarm strobe (write disable) |
| cmd_stat_wr | input | 1 | Status-update strobe |
| stat_wdata | input | 8 | Data byte of the status update |
| cmd_wr_end | input | 1 | End-of-array-write strobe |
| lock_pin_n | input | 1 | External lock pin, active low |
| byte_req | input | 1 | Grant request for `byte_addr` |
| byte_addr | input | ADDR_W | Array address to be checked |
| stat_q | output | 8 | Status byte |
| byte_grant | output | 1 | Registered write grant |

## Verification
The bench builds the block with the default ADDR_W of 15. With that width, the region boundaries at 0x3FFF/0x4000, 0x5FFF/0x6000 and 0x7FFF are exact addresses the bench can drive. A reference model in the bench tracks the latch, the selector and the pin-enable bit from the requirements alone. The bench walks the block through rejected and accepted status updates, arm and clear collisions, and both reset kinds, and it checks every selector code at its edge addresses.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;
  localparam int STAT_W     = 8;
  localparam int POS_PINEN  = 7;
  localparam int POS_SEL_HI = 3;
  localparam int POS_SEL_LO = 2;
  localparam int POS_ARM    = 1;

  typedef enum logic [1:0] {
    REGION_NONE = 2'b00,
    REGION_QTR  = 2'b01,
    REGION_HALF = 2'b10,
    REGION_ALL  = 2'b11
  } region_e;
endpackage

// File: rtl/sg_arm_latch.sv
module sg_arm_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic arm_o
);
  always_ff @(posedge clk) begin
    if (rst)        arm_o <= 1'b0;
    else if (clr_i) arm_o <= 1'b0;
    else if (set_i) arm_o <= 1'b1;
  end

  // R2
  arm_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> arm_o);

  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !arm_o);
endmodule

// File: rtl/sg_cfg_bits.sv
module sg_cfg_bits
  import stat_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nv_rst,
  input  logic              upd_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              arm_i,
  input  logic              lock_pin_n,
  output region_e           region_o,
  output logic              pinen_o
);
  logic pin_holds;
  logic accept;

  always_comb begin
    pin_holds = pinen_o && !lock_pin_n;
    accept    = upd_i && arm_i && !pin_holds && !rst;
  end

  always_ff @(posedge clk) begin
    if (nv_rst) begin
      region_o <= REGION_NONE;
      pinen_o  <= 1'b0;
    end else if (accept) begin
      region_o <= region_e'(wdata_i[POS_SEL_HI:POS_SEL_LO]);
      pinen_o  <= wdata_i[POS_PINEN];
    end
  end

  // R4
  unarmed_upd_chk: assert property (@(posedge clk) disable iff (rst || nv_rst)
    (upd_i && !arm_i) |=> ($stable(region_o) && $stable(pinen_o)));

  // R5
  pin_block_chk: assert property (@(posedge clk) disable iff (rst || nv_rst)
    (upd_i && pinen_o && !lock_pin_n) |=> ($stable(region_o) && $stable(pinen_o)));

  // R9
  keep_on_rst_chk: assert property (@(posedge clk) disable iff (nv_rst)
    rst |=> ($stable(region_o) && $stable(pinen_o)));
endmodule

// File: rtl/sg_region_guard.sv
module sg_region_guard
  import stat_guard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              arm_i,
  input  region_e           region_i,
  output logic              grant_o
);
  localparam int TOP = ADDR_W - 1;

  logic in_region;

  always_comb begin
    unique case (region_i)
      REGION_NONE: in_region = 1'b0;
      REGION_QTR:  in_region = addr_i[TOP] && addr_i[TOP-1];
      REGION_HALF: in_region = addr_i[TOP];
      default:     in_region = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) grant_o <= 1'b0;
    else     grant_o <= req_i && arm_i && !in_region;
  end

  // R8
  grant_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> ($past(arm_i) && $past(req_i)));

  // R7
  all_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (region_i == REGION_ALL && $stable(region_i)) |=> !grant_o);
endmodule

// File: rtl/stat_guard.sv
module stat_guard
  import stat_guard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nv_rst,
  input  logic              cmd_arm,
  input  logic              cmd_disarm,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              cmd_wr_end,
  input  logic              lock_pin_n,
  input  logic              byte_req,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        stat_q,
  output logic              byte_grant
);
  logic    any_rst;
  logic    arm_clr;
  logic    arm;
  logic    pinen;
  region_e region;

  always_comb begin
    any_rst = rst || nv_rst;
    arm_clr = cmd_disarm || cmd_wr_end || cmd_stat_wr;
  end

  sg_arm_latch u_arm (
    .clk   (clk),
    .rst   (any_rst),
    .set_i (cmd_arm),
    .clr_i (arm_clr),
    .arm_o (arm)
  );

  sg_cfg_bits u_cfg (
    .clk        (clk),
    .rst        (rst),
    .nv_rst     (nv_rst),
    .upd_i      (cmd_stat_wr),
    .wdata_i    (stat_wdata),
    .arm_i      (arm),
    .lock_pin_n (lock_pin_n),
    .region_o   (region),
    .pinen_o    (pinen)
  );

  sg_region_guard #(.ADDR_W(ADDR_W)) u_guard (
    .clk      (clk),
    .rst      (any_rst),
    .req_i    (byte_req),
    .addr_i   (byte_addr),
    .arm_i    (arm),
    .region_i (region),
    .grant_o  (byte_grant)
  );

  always_comb begin
    stat_q                        = '0;
    stat_q[POS_PINEN]             = pinen;
    stat_q[POS_SEL_HI:POS_SEL_LO] = region;
    stat_q[POS_ARM]               = arm;
  end

  // R1
  status_arm_chk: assert property (@(posedge clk) disable iff (any_rst)
    (cmd_arm && !arm_clr) |=> stat_q[POS_ARM]);
endmodule

// File: tb/stat_guard_tb.sv
module stat_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst, nv_rst, cmd_arm, cmd_disarm, cmd_stat_wr, cmd_wr_end, lock_pin_n, byte_req;
  logic [7:0] stat_wdata;
  logic [AW-1:0] byte_addr;
  logic [7:0] stat_q;
  logic byte_grant;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .nv_rst(nv_rst), .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm),
    .cmd_stat_wr(cmd_stat_wr), .stat_wdata(stat_wdata), .cmd_wr_end(cmd_wr_end),
    .lock_pin_n(lock_pin_n), .byte_req(byte_req), .byte_addr(byte_addr),
    .stat_q(stat_q), .byte_grant(byte_grant)
  );

  typedef struct {
    logic [7:0] st;
    logic       gr;
    string      rid;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  logic m_arm = 1'b0, m_pinen = 1'b0;
  logic [1:0] m_sel = 2'b00;
  bit done = 0;

  function automatic logic locked(input logic [1:0] sel, input logic [AW-1:0] a);
    case (sel)
      2'b00:   return 1'b0;
      2'b01:   return a >= 15'h6000;
      2'b10:   return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (stat_q !== e.st) begin
        errors++;
        $display("FAIL %s status: actual %02h expected %02h", e.rid, stat_q, e.st);
      end
      checks++;
      if (byte_grant !== e.gr) begin
        errors++;
        $display("FAIL %s grant: actual %0b expected %0b", e.rid, byte_grant, e.gr);
      end
    end
  end

  task automatic step(input logic arm, dis, wend, swr, input logic [7:0] sd,
                      input logic pin_n, req, input logic [AW-1:0] addr,
                      input logic rs, nvrs, input string rid);
    exp_t e;
    logic g, acc;
    @(negedge clk);
    cmd_arm = arm; cmd_disarm = dis; cmd_wr_end = wend; cmd_stat_wr = swr;
    stat_wdata = sd; lock_pin_n = pin_n; byte_req = req; byte_addr = addr;
    rst = rs; nv_rst = nvrs;
    g = !rs && !nvrs && req && m_arm && !locked(m_sel, addr);
    if (nvrs) begin
      m_arm = 0; m_sel = 0; m_pinen = 0;
    end else if (rs) begin
      m_arm = 0;
    end else begin
      acc = swr && m_arm && !(m_pinen && !pin_n);
      if (acc) begin
        m_sel = sd[3:2]; m_pinen = sd[7];
      end
      if (dis || wend || swr) m_arm = 0;
      else if (arm)           m_arm = 1;
    end
    @(posedge clk);
    e.st = {m_pinen, 3'b000, m_sel, m_arm, 1'b0};
    e.gr = g;
    e.rid = rid;
    sb.push_back(e);
  endtask

  task automatic idle(input string rid);
    step(0,0,0,0,8'h00,1,0,'0,0,0,rid);
  endtask
  task automatic arm_it(input string rid);
    step(1,0,0,0,8'h00,1,0,'0,0,0,rid);
  endtask
  task automatic upd(input logic [7:0] d, input logic pin_n, input string rid);
    step(0,0,0,1,d,pin_n,0,'0,0,0,rid);
  endtask
  task automatic ask(input logic [AW-1:0] a, input string rid);
    step(0,0,0,0,8'h00,1,1,a,0,0,rid);
  endtask
  task automatic set_region(input logic [7:0] d, input string rid);
    arm_it(rid);
    upd(d, 1'b1, rid);
    arm_it(rid);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(0,0,0,0,8'h00,1,0,'0,1,1,"R9_por");
    idle("R9_por_idle");
    upd(8'h8C, 1, "R4_unarmed");
    arm_it("R2_arm");
    ask(15'h0000, "R8_armed_grant");
    upd(8'hFF, 1, "R6_R1_accept");
    ask(15'h0000, "R8_unarmed");
    arm_it("R2_rearm");
    upd(8'h00, 0, "R5_pin_reject");
    ask(15'h0000, "R3_after_upd");
    arm_it("R2_rearm2");
    upd(8'h04, 1, "R6_pin_high");
    arm_it("R7_qtr");
    ask(15'h5FFF, "R10_qtr_below");
    ask(15'h6000, "R10_qtr_start");
    ask(15'h7FFF, "R7_qtr_top");
    step(0,0,1,0,8'h00,1,0,'0,0,0,"R3_wr_end");
    step(1,1,0,0,8'h00,1,0,'0,0,0,"R3_collision");
    step(1,0,1,0,8'h00,1,0,'0,0,0,"R3_collision_end");
    arm_it("R2_arm3");
    step(0,0,0,0,8'h00,1,0,'0,1,0,"R9_proto_rst");
    ask(15'h0000, "R9_after_rst");
    set_region(8'h08, "R7_half");
    ask(15'h3FFF, "R10_half_below");
    ask(15'h4000, "R10_half_start");
    set_region(8'h0C, "R7_all");
    ask(15'h0000, "R7_all_bottom");
    set_region(8'h00, "R7_none");
    ask(15'h7FFF, "R7_none_top");
    upd(8'h84, 0, "R6_pinen_off_low");
    step(0,0,0,0,8'h00,1,0,'0,0,1,"R9_nv_rst");
    idle("R9_final");
    idle("drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule